// File: doc/BRIEF.md
# Signature Store Decoder

This block sits beside a processor's data-memory write port. A test program reports to its environment by storing words to one reserved address, and the block picks those stores out of the write traffic. It ignores every store that goes to another address or that does not write all four bytes. The block groups the stores into messages and turns each message into event strobes that the surrounding logic can consume.

A message begins with a header word. The least significant byte of the header holds a message type, and the upper three bytes hold an argument whose meaning depends on that type. The type also sets how many payload words follow the header. A status report and a test verdict each fit in the header alone. A control-register report adds one payload word, which is the register's value. A register-file dump adds one payload word for each general register, starting at index 0. While a message is still collecting payload, every matching store counts as payload, whatever its low byte contains.

Each decoded item appears on the outputs for exactly one cycle, in the cycle after the store that completes it.

Top module: `sig_decoder`

## Requirements
- R1: A store is accepted only when `wr_en` is 1, `wr_addr` equals the parameter `SIG_ADDR` (default 0x8FFFFFFC) and `wr_be` is 4'b1111. Any other store produces no output and leaves the message state unchanged.
- R2: In a header word, bits [7:0] give the type and bits [31:8] give the argument. For a control-register report, the register address is bits [19:8].
- R3: A header of type 0x00 causes `status_vld` to pulse, with `status_code` equal to bits [31:8] of the header.
- R4: A header of type 0x01 causes `result_vld` to pulse. `result_pass` is 1 when bits [31:8] of the header are zero, and 0 otherwise.
- R5: A header of type 0x02 is followed by exactly 32 accepted payload words. Payload word k causes `gpr_vld` to pulse with `gpr_idx` = k and `gpr_val` equal to that word. After the 32nd word the decoder returns to idle.
- R6: `gpr_done` is 1 only together with the `gpr_vld` pulse whose `gpr_idx` is 31.
- R7: A header of type 0x03 is followed by one payload word. That word causes `csr_vld` to pulse, with `csr_addr` taken from bits [19:8] of the header and `csr_val` equal to the payload word.
- R8: An accepted store that arrives while a message is collecting payload is always treated as payload. Its low byte is never decoded as a type.
- R9: A header whose type is above 0x03 causes `bad_type` to pulse for one cycle, and the decoder stays idle.
- R10: In any cycle, at most one of `status_vld`, `result_vld`, `gpr_vld`, `csr_vld` and `bad_type` is 1. Each pulse lasts one cycle for each accepted store.
- R11: While `rst` is 1 (synchronous, active high), all strobes go to 0, the decoder returns to idle and the payload count is cleared.
- R12: Every strobe rises in the cycle immediately after the clock edge that accepted the store that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe of the observed memory port |
| wr_addr | input | 32 | Write address |
| wr_be | input | 4 | Byte enables |
| wr_data | input | 32 | Write data |
| status_vld | output | 1 | Status report strobe |
| status_code | output | 24 | Status argument |
| result_vld | output | 1 | Test verdict strobe |
| result_pass | output | 1 | 1 when the verdict is pass |
| gpr_vld | output | 1 | Register-dump item strobe |
| gpr_idx | output | 5 | Register index of the item |
| gpr_val | output | 32 | Register value of the item |
| gpr_done | output | 1 | Marks the last register-dump item |
| csr_vld | output | 1 | Control-register report strobe |
| csr_addr | output | 12 | Control-register address |
| csr_val | output | 32 | Control-register value |
| bad_type | output | 1 | Unknown header type pulse |

## Verification
The case hardest to reach is a payload word that looks like a header, arriving deep inside a register dump, while rejected stores are mixed into the same stretch. Only then can the bench show that the payload count neither skips nor restarts. The stimulus therefore builds the dump values so that several have low bytes of 0x00 to 0x03 or an unknown type code. It also inserts stores with partial byte enables and stores to other addresses between payload words, and resets once in the middle of a dump. A behavioural model in the bench tracks the message state and compares every output on every cycle.

// File: rtl/sigdec_pkg.sv
package sigdec_pkg;
  localparam int WORD_W = 32;
  localparam int TYPE_W = 8;
  localparam int ARG_W  = WORD_W - TYPE_W;

  typedef enum logic [TYPE_W-1:0] {
    MT_STATUS = 8'h00,
    MT_RESULT = 8'h01,
    MT_REGS   = 8'h02,
    MT_CREG   = 8'h03
  } msg_type_e;

  typedef enum logic [1:0] {ST_IDLE, ST_REGS, ST_CREG} dec_state_e;

  function automatic logic [TYPE_W-1:0] hdr_type(input logic [WORD_W-1:0] w);
    return w[TYPE_W-1:0];
  endfunction

  function automatic logic [ARG_W-1:0] hdr_arg(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:TYPE_W];
  endfunction

  function automatic logic verdict_pass(input logic [WORD_W-1:0] w);
    return hdr_arg(w) == '0;
  endfunction
endpackage

// File: rtl/sigdec_match.sv
module sigdec_match #(
  parameter int                ADDR_W   = 32,
  parameter int                BE_W     = 4,
  parameter logic [ADDR_W-1:0] SIG_ADDR = 32'h8FFF_FFFC
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BE_W-1:0]   wr_be,
  output logic              hit
);
  assign hit = wr_en && (wr_addr == SIG_ADDR) && (&wr_be);
endmodule

// File: rtl/sigdec_fsm.sv
module sigdec_fsm
  import sigdec_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int CREG_AW  = 12,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit,
  input  logic [WORD_W-1:0]  data,
  output logic               ev_status,
  output logic               ev_result,
  output logic               ev_reg,
  output logic               ev_creg,
  output logic               ev_bad,
  output logic [IDX_W-1:0]   reg_idx,
  output logic               reg_last,
  output logic [CREG_AW-1:0] creg_addr,
  output logic               busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  dec_state_e         state, state_nxt;
  logic [IDX_W-1:0]   cnt, cnt_nxt;
  logic [CREG_AW-1:0] caddr;
  logic               cap_addr;

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    ev_status = 1'b0;
    ev_result = 1'b0;
    ev_reg    = 1'b0;
    ev_creg   = 1'b0;
    ev_bad    = 1'b0;
    cap_addr  = 1'b0;
    if (hit) begin
      case (state)
        ST_IDLE: begin
          case (hdr_type(data))
            MT_STATUS: ev_status = 1'b1;
            MT_RESULT: ev_result = 1'b1;
            MT_REGS: begin
              state_nxt = ST_REGS;
              cnt_nxt   = '0;
            end
            MT_CREG: begin
              state_nxt = ST_CREG;
              cap_addr  = 1'b1;
            end
            default: ev_bad = 1'b1;
          endcase
        end
        ST_REGS: begin
          ev_reg = 1'b1;
          if (cnt == LAST_IDX) begin
            state_nxt = ST_IDLE;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        ST_CREG: begin
          ev_creg   = 1'b1;
          state_nxt = ST_IDLE;
        end
        default: state_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      caddr <= '0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
      if (cap_addr) caddr <= data[TYPE_W +: CREG_AW];
    end
  end

  assign reg_idx   = cnt;
  assign reg_last  = (cnt == LAST_IDX);
  assign creg_addr = caddr;
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/sig_decoder.sv
module sig_decoder
  import sigdec_pkg::*;
#(
  parameter logic [31:0] SIG_ADDR = 32'h8FFF_FFFC,
  parameter int          NUM_REGS = 32,
  parameter int          CREG_AW  = 12,
  localparam int         IDX_W    = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_addr,
  input  logic [3:0]         wr_be,
  input  logic [31:0]        wr_data,
  output logic               status_vld,
  output logic [23:0]        status_code,
  output logic               result_vld,
  output logic               result_pass,
  output logic               gpr_vld,
  output logic [IDX_W-1:0]   gpr_idx,
  output logic [31:0]        gpr_val,
  output logic               gpr_done,
  output logic               csr_vld,
  output logic [CREG_AW-1:0] csr_addr,
  output logic [31:0]        csr_val,
  output logic               bad_type
);
  logic               hit_w, busy_w;
  logic               ev_status_w, ev_result_w, ev_reg_w, ev_creg_w, ev_bad_w;
  logic [IDX_W-1:0]   reg_idx_w;
  logic               reg_last_w;
  logic [CREG_AW-1:0] creg_addr_w;

  sigdec_match #(.ADDR_W(32), .BE_W(4), .SIG_ADDR(SIG_ADDR)) u_match (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .hit(hit_w)
  );

  sigdec_fsm #(.NUM_REGS(NUM_REGS), .CREG_AW(CREG_AW)) u_fsm (
    .clk(clk), .rst(rst), .hit(hit_w), .data(wr_data),
    .ev_status(ev_status_w), .ev_result(ev_result_w), .ev_reg(ev_reg_w),
    .ev_creg(ev_creg_w), .ev_bad(ev_bad_w), .reg_idx(reg_idx_w),
    .reg_last(reg_last_w), .creg_addr(creg_addr_w), .busy(busy_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_vld  <= 1'b0;
      status_code <= '0;
      result_vld  <= 1'b0;
      result_pass <= 1'b0;
      gpr_vld     <= 1'b0;
      gpr_idx     <= '0;
      gpr_val     <= '0;
      gpr_done    <= 1'b0;
      csr_vld     <= 1'b0;
      csr_addr    <= '0;
      csr_val     <= '0;
      bad_type    <= 1'b0;
    end else begin
      status_vld <= ev_status_w;
      result_vld <= ev_result_w;
      gpr_vld    <= ev_reg_w;
      gpr_done   <= ev_reg_w && reg_last_w;
      csr_vld    <= ev_creg_w;
      bad_type   <= ev_bad_w;
      if (ev_status_w) status_code <= hdr_arg(wr_data);
      if (ev_result_w) result_pass <= verdict_pass(wr_data);
      if (ev_reg_w) begin
        gpr_idx <= reg_idx_w;
        gpr_val <= wr_data;
      end
      if (ev_creg_w) begin
        csr_addr <= creg_addr_w;
        csr_val  <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sigdec_chk.sv
module sigdec_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             hit,
  input logic             busy,
  input logic [31:0]      wr_data,
  input logic             status_vld,
  input logic             result_vld,
  input logic             gpr_vld,
  input logic [IDX_W-1:0] gpr_idx,
  input logic             gpr_done,
  input logic             csr_vld,
  input logic             bad_type
);
  logic any_ev;
  assign any_ev = status_vld | result_vld | gpr_vld | csr_vld | bad_type;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({status_vld, result_vld, gpr_vld, csr_vld, bad_type})); // R10
  AST_NO_HIT_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !any_ev); // R1
  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    gpr_done |-> (gpr_vld && (&gpr_idx))); // R6
  AST_PAYLOAD_NOT_HEADER: assert property (@(posedge clk) disable iff (rst)
    (hit && busy) |=> !(status_vld || result_vld || bad_type)); // R8
  AST_BAD_TYPE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (hit && !busy && (wr_data[7:0] > 8'h03)) |=> (bad_type && !busy)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!any_ev && !busy)); // R11
endmodule

bind sig_decoder sigdec_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .hit(hit_w), .busy(busy_w), .wr_data(wr_data),
  .status_vld(status_vld), .result_vld(result_vld), .gpr_vld(gpr_vld),
  .gpr_idx(gpr_idx), .gpr_done(gpr_done), .csr_vld(csr_vld),
  .bad_type(bad_type)
);

// File: tb/sim_sig_decoder.sv
`timescale 1ns/1ps
module sim_sig_decoder;
  localparam logic [31:0] SIG = 32'h8FFF_FFFC;

  logic clk = 1'b0;
  logic rst, wr_en;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;
  logic        status_vld, result_vld, result_pass, gpr_vld, gpr_done, csr_vld, bad_type;
  logic [23:0] status_code;
  logic [4:0]  gpr_idx;
  logic [31:0] gpr_val, csr_val;
  logic [11:0] csr_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference: 0 idle, 1 register dump, 2 control-register report
  int mode = 0;
  int count = 0;
  int pend_addr = 0;

  always #4 clk = ~clk;

  sig_decoder u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .status_vld(status_vld), .status_code(status_code),
    .result_vld(result_vld), .result_pass(result_pass), .gpr_vld(gpr_vld),
    .gpr_idx(gpr_idx), .gpr_val(gpr_val), .gpr_done(gpr_done),
    .csr_vld(csr_vld), .csr_addr(csr_addr), .csr_val(csr_val),
    .bad_type(bad_type)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; compare at the next falling edge (R12: one cycle later).
  task automatic step(input bit r, input bit en, input logic [31:0] a,
                      input logic [3:0] be, input logic [31:0] d);
    bit e_st = 0, e_rs = 0, e_gp = 0, e_cs = 0, e_bad = 0, e_done = 0, e_pass = 0;
    int e_idx = 0, e_caddr = 0;
    bit take;
    rst = r; wr_en = en; wr_addr = a; wr_be = be; wr_data = d;
    take = !r && en && (a == SIG) && (be == 4'hF);
    if (r) begin
      mode = 0; count = 0;
    end else if (take) begin
      if (mode == 1) begin
        e_gp = 1; e_idx = count; e_done = (count == 31);
        count++;
        if (count == 32) begin mode = 0; count = 0; end
      end else if (mode == 2) begin
        e_cs = 1; e_caddr = pend_addr; mode = 0;
      end else begin
        case (d & 32'hFF)
          0: e_st = 1;
          1: begin e_rs = 1; e_pass = ((d >> 8) == 0); end
          2: begin mode = 1; count = 0; end
          3: begin mode = 2; pend_addr = (d >> 8) & 32'hFFF; end
          default: e_bad = 1;
        endcase
      end
    end
    @(negedge clk);
    chk((status_vld|result_vld|gpr_vld|csr_vld|bad_type) == (e_st|e_rs|e_gp|e_cs|e_bad),
        "R12", status_vld|result_vld|gpr_vld|csr_vld|bad_type, e_st|e_rs|e_gp|e_cs|e_bad);
    chk($countones({status_vld,result_vld,gpr_vld,csr_vld,bad_type}) <= 1, "R10",
        {status_vld,result_vld,gpr_vld,csr_vld,bad_type}, 0);
    chk(status_vld == e_st && (!e_st || status_code == d[31:8]), "R3",
        {status_vld, status_code}, {e_st, d[31:8]});
    chk(result_vld == e_rs && (!e_rs || result_pass == e_pass), "R4",
        {result_vld, result_pass}, {e_rs, e_pass});
    chk(gpr_vld == e_gp && (!e_gp || (gpr_idx == e_idx && gpr_val == d)), "R5",
        {gpr_vld, gpr_idx, gpr_val}, {e_gp, e_idx[4:0], d});
    chk(gpr_done == e_done, "R6", gpr_done, e_done);
    chk(csr_vld == e_cs && (!e_cs || csr_val == d), "R7", {csr_vld, csr_val}, {e_cs, d});
    if (e_cs) chk(csr_addr == e_caddr, "R2", csr_addr, e_caddr);
    chk(bad_type == e_bad, "R9", bad_type, e_bad);
  endtask

  task automatic put(input logic [31:0] d);
    step(0, 1, SIG, 4'hF, d);
  endtask

  task automatic idle();
    step(0, 0, 32'h0, 4'h0, 32'h0);
  endtask

  initial begin
    rst = 1; wr_en = 0; wr_addr = 0; wr_be = 0; wr_data = 0;
    @(negedge clk);
    // R11: outputs cleared under reset
    step(1, 0, 0, 0, 0);
    step(1, 1, SIG, 4'hF, 32'h0000_0000);
    idle();
    // R3 status, R4 pass and fail verdicts
    put(32'h0000_0200);
    put(32'hABCD_EF00);
    put(32'h0000_0001);
    put(32'h0000_0101);
    // R1: wrong address, partial enables, no write enable
    step(0, 1, SIG - 4, 4'hF, 32'h0000_0700);
    step(0, 1, SIG, 4'h7, 32'h0000_0000);
    step(0, 0, SIG, 4'hF, 32'h0000_0000);
    // R7 / R2: control-register report with junk between header and value
    put(32'hFFF3_0403);
    step(0, 1, SIG, 4'hE, 32'h1111_1111);
    step(0, 1, 32'h8000_0000, 4'hF, 32'h2222_2222);
    put(32'h0000_0000);
    put(32'h0012_3403);
    put(32'hDEAD_BEEF);
    // R9: unknown type, stays idle
    put(32'h0000_007F);
    put(32'h0000_0300);
    put(32'h0000_00FF);
    // R5 / R6 / R8: full register dump, headers disguised as payload
    put(32'h0000_0002);
    for (int i = 0; i < 32; i++) begin
      if (i % 5 == 2) step(0, 1, SIG, 4'h3, 32'h0000_0001);
      if (i % 7 == 3) step(0, 1, SIG ^ 32'h10, 4'hF, 32'h0000_0003);
      put((i * 32'h0101_0100) | (i % 6));
    end
    put(32'h0000_0500);
    // R11: reset in the middle of a dump, then a fresh header
    put(32'h0000_0002);
    put(32'h1234_5678);
    put(32'h0000_0003);
    step(1, 0, 0, 0, 0);
    put(32'h0000_0900);
    // back-to-back dump to end
    put(32'h0000_0002);
    for (int i = 0; i < 32; i++) put(32'hC0DE_0000 + i);
    put(32'h0000_0001);
    idle();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule